// File: doc/BRIEF.md
# DAC Power-Up Configuration Sequencer

This block sits on the host side of a multi-channel DAC and puts the converter into a known state after a system reset. When it gets a one-cycle start pulse, it resets the DAC in one of two ways. It can pulse a dedicated active-high reset pin for a timed interval, or it can send a keyed reset command over the serial link. It then waits a minimum settling interval and sends a fixed, ordered set of configuration frames. The last of these frames programs the output span. After that it raises a done flag.

Frames leave through a 24-bit valid/ready frame port. A separate SPI shifter owns that port and serialises each accepted word. Each frame word carries an 8-bit command in bits 23:16 and a 16-bit argument in bits 15:0. The pulse width and the settling wait are given in nanoseconds and are converted to whole clock cycles, rounded up, from the clock frequency parameter. The reset method and the span code are sampled on the start pulse.

Top module: `dac_init_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `frm_valid`, `dac_rst_pin` and `done` are all low.
- R2: When `hw_rst_sel` is 1 at the start pulse, `dac_rst_pin` goes high in the cycle after the start and stays high for exactly PULSE_CYC cycles, where PULSE_CYC = ceil(100 ns × CLK_MHZ / 1000). No frame is offered while the pin is high.
- R3: When `hw_rst_sel` is 0 at the start pulse, the pin stays low and the first frame offered is command 0x70 with argument 0x1234 (word 0x701234).
- R4: After the reset completes, meaning the pin falls or the reset frame is accepted, `frm_valid` stays low for exactly WAIT_CYC cycles, where WAIT_CYC = ceil(25 ns × CLK_MHZ / 1000). The first configuration frame follows.
- R5: The configuration frames follow the reset in this order: 0x51FFFF (dither powered down on all channels), 0x905555, 0xA05555 (dither source bit 0 set for each channel), 0xC00000, 0xD00000, 0xB00000, and finally the span frame. The command is in bits 23:16 and the argument in bits 15:0.
- R6: The span frame is last. Its command is 0x40 and its argument is the span code captured at the start pulse, zero-extended to 16 bits. Later changes to `span_code` have no effect.
- R7: A frame stays on `frm_data`, with `frm_valid` high, until a cycle in which `frm_ready` is high.
- R8: `done` rises in the cycle after the last frame is accepted and stays high until `rst`. While `done` is high, no frame is offered and the pin stays low.
- R9: A start pulse that arrives while the sequence is running, or after `done`, is ignored. No frame is repeated and the sequence does not restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin the sequence |
| hw_rst_sel | input | 1 | 1: reset through the pin, 0: keyed reset frame |
| span_code | input | SPAN_W (3) | Output span code written by the last frame |
| frm_valid | output | 1 | A frame word is offered |
| frm_data | output | 24 | Frame word: command in [23:16], argument in [15:0] |
| frm_ready | input | 1 | The shifter accepts the offered frame |
| dac_rst_pin | output | 1 | Active-high DAC reset pin |
| done | output | 1 | Configuration complete, held until reset |

## Verification
The bench sweeps every span code under both reset methods. A frame port stub stalls for a varying number of cycles on each frame. Against that, it checks that frames are neither dropped nor altered while they wait. A design that sends the span before the reset, skips a frame, or latches the span late would show a wrong word at a known position in the captured list. A pulse or wait counter off by one shows up as a pin width or an idle gap one cycle away from the computed value. A design that re-arms on start would emit a second reset or repeat frames when start is pulsed in mid-sequence or after done. A late done flag shows up as a rise one cycle off from the last handshake.

// File: rtl/dis_pkg.sv
package dis_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_SWRST,
        ST_WAIT,
        ST_CFG,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [15:0] arg;
    } frame_t;

    localparam logic [7:0]  CMD_KEY_RESET = 8'h70;
    localparam logic [15:0] KEY_RESET_ARG = 16'h1234;
    localparam logic [7:0]  CMD_DITH_PWR  = 8'h51;
    localparam logic [7:0]  CMD_SRC_LO    = 8'h90;
    localparam logic [7:0]  CMD_SRC_HI    = 8'hA0;
    localparam logic [7:0]  CMD_SCL_LO    = 8'hC0;
    localparam logic [7:0]  CMD_SCL_HI    = 8'hD0;
    localparam logic [7:0]  CMD_INVERT    = 8'hB0;
    localparam logic [7:0]  CMD_SPAN      = 8'h40;

    localparam int CFG_COUNT = 7;
    localparam int IDX_W     = $clog2(CFG_COUNT);

    // Whole clock cycles covering a minimum time, rounded up.
    function automatic int ns_to_cycles(input int ns, input int mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    // Power-down mask: one bit per channel.
    function automatic logic [15:0] pd_mask(input int nch);
        logic [15:0] m;
        m = '0;
        for (int i = 0; i < 16; i++) begin
            if (i < nch) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Source selection word: two bits per channel, low bit selects the first source.
    function automatic logic [15:0] src_word(input int nch, input int base);
        logic [15:0] w;
        w = '0;
        for (int c = 0; c < 8; c++) begin
            if (c + base < nch) w[2*c] = 1'b1;
        end
        return w;
    endfunction

    function automatic frame_t key_reset_frame();
        frame_t f;
        f.cmd = CMD_KEY_RESET;
        f.arg = KEY_RESET_ARG;
        return f;
    endfunction

    function automatic frame_t cfg_frame(input logic [IDX_W-1:0] idx,
                                         input logic [15:0] span16,
                                         input int nch);
        frame_t f;
        f.arg = '0;
        case (idx)
            3'd0: begin f.cmd = CMD_DITH_PWR; f.arg = pd_mask(nch); end
            3'd1: begin f.cmd = CMD_SRC_LO;   f.arg = src_word(nch, 0); end
            3'd2: begin f.cmd = CMD_SRC_HI;   f.arg = src_word(nch, 8); end
            3'd3: f.cmd = CMD_SCL_LO;
            3'd4: f.cmd = CMD_SCL_HI;
            3'd5: f.cmd = CMD_INVERT;
            default: begin f.cmd = CMD_SPAN; f.arg = span16; end
        endcase
        return f;
    endfunction

endpackage

// File: rtl/dis_timer.sv
module dis_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/dis_frame_rom.sv
module dis_frame_rom
    import dis_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int SPAN_W = 3
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [SPAN_W-1:0] span,
    input  logic              key_sel,
    output frame_t            frame
);
    logic [15:0] span16;
    assign span16 = 16'(span);

    always_comb begin
        if (key_sel) frame = key_reset_frame();
        else         frame = cfg_frame(idx, span16, NUM_CH);
    end
endmodule

// File: rtl/dis_seq_fsm.sv
module dis_seq_fsm
    import dis_pkg::*;
#(
    parameter int PULSE_CYC = 20,
    parameter int WAIT_CYC  = 5,
    parameter int SPAN_W    = 3,
    parameter int TMR_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              hw_sel,
    input  logic [SPAN_W-1:0] span_in,
    input  logic              frm_ready,
    input  logic              tmr_expired,
    output seq_state_t        state,
    output logic [IDX_W-1:0]  cfg_idx,
    output logic [SPAN_W-1:0] span_q,
    output logic              tmr_load,
    output logic [TMR_W-1:0]  tmr_val
);
    localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(CFG_COUNT - 1);
    localparam logic [TMR_W-1:0] PULSE_LOAD = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] WAIT_LOAD  = TMR_W'(WAIT_CYC - 1);

    seq_state_t       nxt;
    logic [IDX_W-1:0] idx_nxt;

    always_comb begin
        nxt      = state;
        idx_nxt  = cfg_idx;
        tmr_load = 1'b0;
        tmr_val  = WAIT_LOAD;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    idx_nxt = '0;
                    if (hw_sel) begin
                        nxt      = ST_PULSE;
                        tmr_load = 1'b1;
                        tmr_val  = PULSE_LOAD;
                    end else begin
                        nxt = ST_SWRST;
                    end
                end
            end
            ST_PULSE: begin
                if (tmr_expired) begin
                    nxt      = ST_WAIT;
                    tmr_load = 1'b1;
                end
            end
            ST_SWRST: begin
                if (frm_ready) begin
                    nxt      = ST_WAIT;
                    tmr_load = 1'b1;
                end
            end
            ST_WAIT: begin
                if (tmr_expired) nxt = ST_CFG;
            end
            ST_CFG: begin
                if (frm_ready) begin
                    if (cfg_idx == LAST_IDX) nxt = ST_DONE;
                    else                     idx_nxt = cfg_idx + 1'b1;
                end
            end
            default: nxt = ST_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg_idx <= '0;
            span_q  <= '0;
        end else begin
            state   <= nxt;
            cfg_idx <= idx_nxt;
            if (state == ST_IDLE && start) span_q <= span_in;
        end
    end
endmodule

// File: rtl/dac_init_seq.sv
module dac_init_seq
    import dis_pkg::*;
#(
    parameter int CLK_MHZ      = 200,
    parameter int RST_PULSE_NS = 100,
    parameter int POST_RST_NS  = 25,
    parameter int NUM_CH       = 16,
    parameter int SPAN_W       = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              hw_rst_sel,
    input  logic [SPAN_W-1:0] span_code,
    output logic              frm_valid,
    output logic [23:0]       frm_data,
    input  logic              frm_ready,
    output logic              dac_rst_pin,
    output logic              done
);
    localparam int PULSE_CYC = ns_to_cycles(RST_PULSE_NS, CLK_MHZ);
    localparam int WAIT_CYC  = ns_to_cycles(POST_RST_NS, CLK_MHZ);
    localparam int MAX_CYC   = (PULSE_CYC > WAIT_CYC) ? PULSE_CYC : WAIT_CYC;
    localparam int TMR_W     = $clog2(MAX_CYC + 1);

    seq_state_t        state;
    logic [IDX_W-1:0]  cfg_idx;
    logic [SPAN_W-1:0] span_q;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;
    frame_t            frame;

    dis_seq_fsm #(
        .PULSE_CYC (PULSE_CYC),
        .WAIT_CYC  (WAIT_CYC),
        .SPAN_W    (SPAN_W),
        .TMR_W     (TMR_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .hw_sel      (hw_rst_sel),
        .span_in     (span_code),
        .frm_ready   (frm_ready),
        .tmr_expired (tmr_expired),
        .state       (state),
        .cfg_idx     (cfg_idx),
        .span_q      (span_q),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val)
    );

    dis_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    dis_frame_rom #(.NUM_CH(NUM_CH), .SPAN_W(SPAN_W)) u_rom (
        .idx     (cfg_idx),
        .span    (span_q),
        .key_sel (state == ST_SWRST),
        .frame   (frame)
    );

    assign frm_valid   = (state == ST_SWRST) || (state == ST_CFG);
    assign frm_data    = frame;
    assign dac_rst_pin = (state == ST_PULSE);
    assign done        = (state == ST_DONE);
endmodule

// File: rtl/dac_init_seq_chk.sv
module dac_init_seq_chk
    import dis_pkg::*;
#(
    parameter int CLK_MHZ      = 200,
    parameter int RST_PULSE_NS = 100
) (
    input logic        clk,
    input logic        rst,
    input logic        frm_valid,
    input logic [23:0] frm_data,
    input logic        frm_ready,
    input logic        dac_rst_pin,
    input logic        done
);
    localparam int PULSE_CYC = ns_to_cycles(RST_PULSE_NS, CLK_MHZ);

    logic [15:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (rst)              hi_cnt <= '0;
        else if (dac_rst_pin) hi_cnt <= hi_cnt + 1'b1;
        else                  hi_cnt <= '0;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!frm_valid && !done && !dac_rst_pin));

    a_r7_frame_hold: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_data)));

    a_r2_pin_no_frame: assert property (@(posedge clk) disable iff (rst)
        dac_rst_pin |-> !frm_valid);

    a_r2_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_rst_pin) |-> (hi_cnt == 16'(PULSE_CYC)));

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!frm_valid && !dac_rst_pin));
endmodule

bind dac_init_seq dac_init_seq_chk #(
    .CLK_MHZ      (CLK_MHZ),
    .RST_PULSE_NS (RST_PULSE_NS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frm_valid   (frm_valid),
    .frm_data    (frm_data),
    .frm_ready   (frm_ready),
    .dac_rst_pin (dac_rst_pin),
    .done        (done)
);

// File: tb/dac_init_seq_test.sv
`timescale 1ns/1ps
module dac_init_seq_test;
    localparam int MHZ = 200;
    localparam int P   = (100 * MHZ + 999) / 1000;
    localparam int W   = (25 * MHZ + 999) / 1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        hw_sel = 1'b0;
    logic [2:0]  span = 3'd0;
    logic        ready = 1'b0;
    logic        valid, pin, done;
    logic [23:0] data;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    dac_init_seq uut (
        .clk(clk), .rst(rst), .start(start), .hw_rst_sel(hw_sel),
        .span_code(span), .frm_valid(valid), .frm_data(data),
        .frm_ready(ready), .dac_rst_pin(pin), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_cfg(input int j, input logic [2:0] sp);
        case (j)
            0: return 24'h51FFFF;
            1: return 24'h905555;
            2: return 24'hA05555;
            3: return 24'hC00000;
            4: return 24'hD00000;
            5: return 24'hB00000;
            default: return {8'h40, 13'd0, sp};
        endcase
    endfunction

    task automatic run(input bit hw, input logic [2:0] sp, input bit inject, input int seed);
        logic [23:0] got [0:15];
        int n_got = 0, hi = 0, gap = 0, waitc = 0, k;
        int last_cyc = -1, done_cyc = -1, exp_n;
        bit rst_seen = 0, cfg_started = 0, injected = 0;
        bit hold_bad = 0, overlap_bad = 0, post_bad = 0;
        bit prev_valid = 0, prev_ready = 0;
        logic [23:0] prev_data = '0;
        exp_n = hw ? 7 : 8;

        rst = 1'b1; start = 1'b0; ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!valid && !pin && !done, "R1", "reset state", {valid, pin, done}, 0);

        hw_sel = hw; span = sp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        span = ~sp;

        for (int cyc = 0; cyc < 2000; cyc++) begin
            k = (seed + n_got) % 3;
            if (prev_valid && !prev_ready && (!valid || data != prev_data)) hold_bad = 1;
            if (pin) begin
                hi++;
                rst_seen = 1;
                if (valid) overlap_bad = 1;
            end
            if (valid) begin
                if (rst_seen) cfg_started = 1;
                if (waitc >= k) begin
                    if (n_got < 16) got[n_got] = data;
                    n_got++;
                    ready = 1'b1;
                    waitc = 0;
                    if (!hw && n_got == 1) rst_seen = 1;
                    if (n_got == exp_n) last_cyc = cyc;
                end else begin
                    ready = 1'b0;
                    waitc++;
                end
            end else begin
                ready = 1'b0;
                if (rst_seen && !cfg_started && !pin) gap++;
            end
            if (done_cyc >= 0 && (!done || valid || pin)) post_bad = 1;
            if (done && done_cyc < 0) done_cyc = cyc;
            start = 1'b0;
            if (inject && n_got == 3 && !injected) begin
                start = 1'b1;
                injected = 1;
            end
            if (done_cyc >= 0 && cyc == done_cyc + 2) start = 1'b1;
            prev_valid = valid; prev_ready = ready; prev_data = data;
            if (done_cyc >= 0 && cyc >= done_cyc + 12) break;
            @(negedge clk);
        end
        start = 1'b0; ready = 1'b0;

        chk(done_cyc >= 0, "R8", "done reached", done_cyc, 1);
        chk(n_got == exp_n, "R9", "frame count", n_got, exp_n);
        chk(hi == (hw ? P : 0), hw ? "R2" : "R3", "pin high cycles", hi, hw ? P : 0);
        if (!hw && n_got > 0)
            chk(got[0] == 24'h701234, "R3", "key reset frame", got[0], 24'h701234);
        chk(gap == W, "R4", "post-reset idle cycles", gap, W);
        for (int j = 0; j < 7; j++) begin
            int pos = j + (hw ? 0 : 1);
            if (pos < n_got && pos < 16)
                chk(got[pos] == exp_cfg(j, sp), (j == 6) ? "R6" : "R5",
                    "config frame", got[pos], exp_cfg(j, sp));
        end
        chk(done_cyc == last_cyc + 1, "R8", "done rise cycle", done_cyc, last_cyc + 1);
        chk(!hold_bad, "R7", "frame held while stalled", hold_bad, 0);
        chk(!overlap_bad, "R2", "no frame while pin high", overlap_bad, 0);
        chk(!post_bad, "R9", "quiet and done after late start", post_bad, 0);
        if (inject)
            chk(injected && n_got == exp_n, "R9", "mid-run start ignored", n_got, exp_n);
    endtask

    initial begin
        for (int hw = 0; hw < 2; hw++) begin
            for (int sp = 0; sp < 8; sp++) begin
                run(hw[0], 3'(sp), (sp == 5) || (sp == 2), sp + hw);
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule